// File: doc/BRIEF.md
# Two-Level Gated Interrupt Aggregator

This block gathers interrupt events from a host controller, a dual-role (OTG) controller and a device controller and presents them on one or two processor interrupt pins. Two first-level groups each hold sticky event bits with their own enable mask. The first group has 6 operational events and an extra master enable. The second group has 11 OTG events and no master enable. Each group's gated OR sets a summary bit in a 10-bit top-level status register. That register has its own enable mask, and its gated OR drives the first pin.

The first pin passes through an output latch that software can freeze. While it is frozen, the pin keeps its state whatever happens in the status or enable registers. Both pins have a selectable polarity. The first pin can work in level mode, or in pulse mode, where each new request gives a pulse of fixed length. The device controller's own interrupt normally drives the second pin. It can instead be merged onto the first pin. Software clears status bits by writing ones to them. The register file that turns bus writes into the clear strobes and enable levels sits outside this block.

Top module: `irq_tree`

## Requirements
- R1: Operational status bit i (`op_sts[i]`) is set in the cycle after `op_evt[i]` is high. It stays set until `op_clr[i]` is high for a cycle. If an event and a clear reach the same bit in the same cycle, the bit stays set. OTG and top-level status bits follow the same rule with their own event and clear inputs.
- R2: Top-level status bit 0 (the operational summary) is set one cycle after a status bit in `op_sts & op_en` is set while `op_mie` is 1. While `op_mie` is 0, the operational group does not set it.
- R3: Top-level status bit 1 (the OTG summary) is set one cycle after a status bit in `otg_sts & otg_en` is set. No master enable applies.
- R4: Event `ext_evt[i]` sets top-level status bit i+2. In level mode with the latch open, the first pin becomes active one cycle after `top_sts & top_en` becomes nonzero. A status bit whose enable is 0 does not activate the pin.
- R5: While `pin_en` is 0, the first pin holds its value, even while status bits are cleared or set. After `pin_en` returns to 1, the pin follows the request again from the next cycle.
- R6: When `merge_pins` is 1, `dev_irq` also drives the first pin, one cycle later, and the second pin stays inactive. When `merge_pins` is 0, the second pin follows `dev_irq` in the same cycle.
- R7: With `pol_high` = 1, both pins are active high. With `pol_high` = 0, both pins are active low.
- R8: In pulse mode (`pulse_mode` = 1), a rising edge of the first pin's request gives an active pulse of exactly PULSE_W cycles. The status bit that caused it stays set after the pulse ends.
- R9: If the request falls and rises again during an active pulse, the pulse is neither stretched nor retriggered, and no new pulse follows it.
- R10: After reset, all status bits are 0 and both pins are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_evt | input | 6 | Operational event strobes |
| op_clr | input | 6 | Write-one-to-clear strobes for operational status |
| op_en | input | 6 | Operational enable mask |
| op_mie | input | 1 | Master enable of the operational group |
| otg_evt | input | 11 | OTG event strobes |
| otg_clr | input | 11 | Write-one-to-clear strobes for OTG status |
| otg_en | input | 11 | OTG enable mask |
| ext_evt | input | 8 | Other top-level events, setting status bits 9..2 |
| top_clr | input | 10 | Write-one-to-clear strobes for top-level status |
| top_en | input | 10 | Top-level enable mask |
| dev_irq | input | 1 | Device controller interrupt, active high |
| pin_en | input | 1 | Opens the first pin's latch; 0 freezes it |
| merge_pins | input | 1 | Routes dev_irq onto the first pin |
| pol_high | input | 1 | 1 = pins active high, 0 = active low |
| pulse_mode | input | 1 | 1 = pulse mode on the first pin, 0 = level mode |
| op_sts | output | 6 | Operational status |
| otg_sts | output | 11 | OTG status |
| top_sts | output | 10 | Top-level status |
| irq_pin_a | output | 1 | First interrupt pin (host/OTG, optionally merged) |
| irq_pin_b | output | 1 | Second interrupt pin (device) |

## Verification
The assertions check on every cycle that set status bits persist unless cleared, that an event always wins over a clear, that the operational summary rises only while the master enable was set, that a frozen latch keeps its level and pulse count, and that a pulse always starts at full length and only counts down. The number of cycles from an event to the pin, the masking by each enable level, the hand-off between the two pins on merge, polarity, and the exact pulse width when the request drops and returns during a pulse can only be shown by the bench's directed scenarios.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
    localparam int OP_N        = 6;
    localparam int OTG_N       = 11;
    localparam int TOP_N       = 10;
    localparam int OP_SUM_BIT  = 0;
    localparam int OTG_SUM_BIT = 1;
    localparam int EXT_N       = TOP_N - 2;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] en,
    input  logic         mie,
    output logic [W-1:0] sts,
    output logic         req
);
    typedef struct packed {
        logic [W-1:0] sts;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // An event outranks a clear that reaches the same bit
        st_d.sts = (st_q.sts & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign req = mie & (|(st_q.sts & en));

    // R1: a set bit that was not cleared is still set
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.sts) & ~$past(clr) & ~st_q.sts) == '0));
    // R1: every event leaves its bit set, clear or not
    a_r1_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~st_q.sts) == '0));
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
    parameter int PULSE_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pin_en,
    input  logic pulse_mode,
    output logic active
);
    localparam int CW = $clog2(PULSE_W + 1);

    typedef struct packed {
        logic          lvl;
        logic          prev;
        logic [CW-1:0] cnt;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pin_en) begin
            st_d.lvl  = req;
            st_d.prev = req;
            if (st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
            else if (pulse_mode && req && !st_q.prev)
                st_d.cnt = CW'(PULSE_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = pulse_mode ? (st_q.cnt != '0) : st_q.lvl;

    // R5: a frozen latch keeps both its level and its pulse count
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> (st_q.lvl == $past(st_q.lvl)) && (st_q.cnt == $past(st_q.cnt)));
    // R9: a running pulse only counts down, never reloads
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    // R8: each pulse starts at full length
    a_r8_full_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cnt != '0) |-> (st_q.cnt == CW'(PULSE_W)));
endmodule

// File: rtl/irq_tree.sv
module irq_tree
    import irq_tree_pkg::*;
#(
    parameter int PULSE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_N-1:0]  op_evt,
    input  logic [OP_N-1:0]  op_clr,
    input  logic [OP_N-1:0]  op_en,
    input  logic             op_mie,
    input  logic [OTG_N-1:0] otg_evt,
    input  logic [OTG_N-1:0] otg_clr,
    input  logic [OTG_N-1:0] otg_en,
    input  logic [EXT_N-1:0] ext_evt,
    input  logic [TOP_N-1:0] top_clr,
    input  logic [TOP_N-1:0] top_en,
    input  logic             dev_irq,
    input  logic             pin_en,
    input  logic             merge_pins,
    input  logic             pol_high,
    input  logic             pulse_mode,
    output logic [OP_N-1:0]  op_sts,
    output logic [OTG_N-1:0] otg_sts,
    output logic [TOP_N-1:0] top_sts,
    output logic             irq_pin_a,
    output logic             irq_pin_b
);
    logic op_req, otg_req, top_req, host_req, a_active, b_active;
    logic [TOP_N-1:0] top_evt;

    irq_group #(.W(OP_N)) u_op (
        .clk(clk), .rst_n(rst_n), .evt(op_evt), .clr(op_clr), .en(op_en),
        .mie(op_mie), .sts(op_sts), .req(op_req)
    );

    irq_group #(.W(OTG_N)) u_otg (
        .clk(clk), .rst_n(rst_n), .evt(otg_evt), .clr(otg_clr), .en(otg_en),
        .mie(1'b1), .sts(otg_sts), .req(otg_req)
    );

    always_comb begin
        top_evt              = '0;
        top_evt[TOP_N-1:2]   = ext_evt;
        top_evt[OP_SUM_BIT]  = op_req;
        top_evt[OTG_SUM_BIT] = otg_req;
    end

    irq_group #(.W(TOP_N)) u_top (
        .clk(clk), .rst_n(rst_n), .evt(top_evt), .clr(top_clr), .en(top_en),
        .mie(1'b1), .sts(top_sts), .req(top_req)
    );

    assign host_req = top_req | (merge_pins & dev_irq);

    irq_pin_drv #(.PULSE_W(PULSE_W)) u_pin (
        .clk(clk), .rst_n(rst_n), .req(host_req), .pin_en(pin_en),
        .pulse_mode(pulse_mode), .active(a_active)
    );

    assign b_active  = dev_irq & ~merge_pins;
    assign irq_pin_a = a_active ^ ~pol_high;
    assign irq_pin_b = b_active ^ ~pol_high;

    // R2: the operational summary rises only if the master enable was set
    a_r2_mie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_sts[OP_SUM_BIT]) |-> $past(op_mie));
    // R3: the OTG summary rises only after an enabled OTG bit was set
    a_r3_otg_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_sts[OTG_SUM_BIT]) |-> $past(|(otg_sts & otg_en)));
endmodule

// File: tb/test_irq_tree.sv
`timescale 1ns/1ps
module test_irq_tree;
    localparam int PW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_evt = '0, op_clr = '0, op_en = '1;
    logic        op_mie = 1'b1;
    logic [10:0] otg_evt = '0, otg_clr = '0, otg_en = '1;
    logic [7:0]  ext_evt = '0;
    logic [9:0]  top_clr = '0, top_en = '1;
    logic        dev_irq = 1'b0, pin_en = 1'b1, merge_pins = 1'b0;
    logic        pol_high = 1'b1, pulse_mode = 1'b0;
    logic [5:0]  op_sts;
    logic [10:0] otg_sts;
    logic [9:0]  top_sts;
    logic        irq_pin_a, irq_pin_b;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_tree #(.PULSE_W(PW)) i_irq_tree (
        .clk(clk), .rst_n(rst_n), .op_evt(op_evt), .op_clr(op_clr), .op_en(op_en),
        .op_mie(op_mie), .otg_evt(otg_evt), .otg_clr(otg_clr), .otg_en(otg_en),
        .ext_evt(ext_evt), .top_clr(top_clr), .top_en(top_en), .dev_irq(dev_irq),
        .pin_en(pin_en), .merge_pins(merge_pins), .pol_high(pol_high),
        .pulse_mode(pulse_mode), .op_sts(op_sts), .otg_sts(otg_sts),
        .top_sts(top_sts), .irq_pin_a(irq_pin_a), .irq_pin_b(irq_pin_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic nstep(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all;
        op_clr = '1; otg_clr = '1; top_clr = '1;
        nstep(3);
        op_clr = '0; otg_clr = '0; top_clr = '0;
        nstep(2);
    endtask

    task automatic t_reset;
        chk("R10 op_sts", 32'(op_sts), 0);
        chk("R10 otg_sts", 32'(otg_sts), 0);
        chk("R10 top_sts", 32'(top_sts), 0);
        chk("R10 pin a", 32'(irq_pin_a), 0);
        chk("R10 pin b", 32'(irq_pin_b), 0);
    endtask

    task automatic t_op_path;
        op_evt = 6'b000100; nstep(1); op_evt = '0;
        chk("R1 op bit set", 32'(op_sts), 32'h4);
        nstep(1);
        chk("R2 op summary", 32'(top_sts), 32'h1);
        nstep(1);
        chk("R4 pin active", 32'(irq_pin_a), 1);
        op_clr = 6'b000100; nstep(1); op_clr = '0;
        chk("R1 op cleared", 32'(op_sts), 0);
        chk("R1 summary re-set by event", 32'(top_sts), 32'h1);
        top_clr = 10'h1; nstep(1); top_clr = '0;
        chk("R1 top cleared", 32'(top_sts), 0);
        nstep(1);
        chk("R4 pin inactive", 32'(irq_pin_a), 0);
        op_evt = 6'b000001; op_clr = 6'b000001; nstep(1);
        op_evt = '0; op_clr = '0;
        chk("R1 event beats clear", 32'(op_sts), 32'h1);
        clear_all();
    endtask

    task automatic t_mie;
        op_mie = 1'b0;
        op_evt = 6'b000001; nstep(1); op_evt = '0;
        nstep(2);
        chk("R2 status still set", 32'(op_sts), 32'h1);
        chk("R2 summary masked", 32'(top_sts), 0);
        chk("R2 pin masked", 32'(irq_pin_a), 0);
        op_mie = 1'b1; nstep(1);
        chk("R2 summary after mie", 32'(top_sts), 32'h1);
        nstep(1);
        chk("R2 pin after mie", 32'(irq_pin_a), 1);
        clear_all();
    endtask

    task automatic t_otg;
        op_mie = 1'b0;
        otg_evt = 11'h400; nstep(1); otg_evt = '0;
        chk("R3 otg bit set", 32'(otg_sts), 32'h400);
        nstep(1);
        chk("R3 otg summary", 32'(top_sts), 32'h2);
        nstep(1);
        chk("R3 pin active", 32'(irq_pin_a), 1);
        op_mie = 1'b1;
        clear_all();
    endtask

    task automatic t_top;
        top_en = 10'h1ff;
        ext_evt = 8'h80; nstep(1); ext_evt = '0;
        chk("R4 ext to top bit 9", 32'(top_sts), 32'h200);
        nstep(1);
        chk("R4 disabled bit no pin", 32'(irq_pin_a), 0);
        top_en = '1; nstep(1);
        chk("R4 enabled bit pin", 32'(irq_pin_a), 1);
        clear_all();
        chk("R4 pin after clear", 32'(irq_pin_a), 0);
    endtask

    task automatic t_freeze;
        ext_evt = 8'h01; nstep(1); ext_evt = '0;
        nstep(1);
        chk("R5 pin active", 32'(irq_pin_a), 1);
        pin_en = 1'b0;
        clear_all();
        chk("R5 status cleared", 32'(top_sts), 0);
        chk("R5 frozen high", 32'(irq_pin_a), 1);
        pin_en = 1'b1; nstep(1);
        chk("R5 unfrozen low", 32'(irq_pin_a), 0);
        pin_en = 1'b0;
        ext_evt = 8'h01; nstep(1); ext_evt = '0;
        nstep(2);
        chk("R5 frozen low", 32'(irq_pin_a), 0);
        pin_en = 1'b1; nstep(1);
        chk("R5 unfrozen high", 32'(irq_pin_a), 1);
        clear_all();
    endtask

    task automatic t_merge;
        chk("R6 pin b idle", 32'(irq_pin_b), 0);
        dev_irq = 1'b1;
        #1;
        chk("R6 pin b follows dev", 32'(irq_pin_b), 1);
        merge_pins = 1'b1; nstep(1);
        chk("R6 merged pin a", 32'(irq_pin_a), 1);
        chk("R6 merged pin b quiet", 32'(irq_pin_b), 0);
        merge_pins = 1'b0; nstep(1);
        chk("R6 split pin a", 32'(irq_pin_a), 0);
        chk("R6 split pin b", 32'(irq_pin_b), 1);
        dev_irq = 1'b0; nstep(1);
    endtask

    task automatic t_pol;
        pol_high = 1'b0; #1;
        chk("R7 pin a idle high", 32'(irq_pin_a), 1);
        chk("R7 pin b idle high", 32'(irq_pin_b), 1);
        dev_irq = 1'b1; #1;
        chk("R7 pin b active low", 32'(irq_pin_b), 0);
        dev_irq = 1'b0;
        nstep(1);
        ext_evt = 8'h02; nstep(1); ext_evt = '0;
        nstep(1);
        chk("R7 pin a active low", 32'(irq_pin_a), 0);
        clear_all();
        chk("R7 pin a back high", 32'(irq_pin_a), 1);
        pol_high = 1'b1; nstep(1);
    endtask

    task automatic t_pulse;
        pulse_mode = 1'b1;
        ext_evt = 8'h02; nstep(1); ext_evt = '0;
        nstep(1);
        chk("R8 pulse start", 32'(irq_pin_a), 1);
        top_clr = 10'h008; nstep(1); top_clr = '0;
        ext_evt = 8'h04; nstep(1); ext_evt = '0;
        nstep(PW - 3);
        chk("R8 pulse last cycle", 32'(irq_pin_a), 1);
        nstep(1);
        chk("R9 pulse not stretched", 32'(irq_pin_a), 0);
        nstep(3);
        chk("R9 no retrigger", 32'(irq_pin_a), 0);
        chk("R8 status kept", 32'(top_sts), 32'h010);
        clear_all();
        pulse_mode = 1'b0;
        nstep(1);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        nstep(3);
        t_reset();
        rst_n = 1'b1;
        nstep(2);
        t_reset();
        t_op_path();
        t_mie();
        t_otg();
        t_top();
        t_freeze();
        t_merge();
        t_pol();
        t_pulse();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule